// File: doc/BRIEF.md
# SPI Slave Command and Extended Address Decoder

This block is the serial front end of a register space. It listens to an SPI master in mode 0: clock idles low, data is captured on the rising edge and changed on the falling edge, most significant bit first. Each transaction is framed by chip select. The block decodes the header of each frame into a 16-bit byte address and an operation. It then performs byte writes or byte reads on a simple register port. The address advances by one for every data byte until chip select is released.

Some masters can only move bytes in groups of two or four. For them, the header can be padded with address-extension bytes, and any number of these may be chained. Each extension byte supplies the top three address bits and a new operation code, and the last extension byte in the chain decides both. Reads always carry one wait byte before the first returned byte. The next read byte is fetched one byte ahead, so each returned byte is already on MISO before the first rising clock edge of its byte time.

All SPI inputs are resynchronised into the system clock domain. The SCLK half period must therefore be at least six system clock cycles.

Top module: `spi_xaddr_slave`

## Requirements
- R1: After reset, and while chip select is high, spi_miso is 0 and neither reg_wr nor reg_rd is pulsed.
- R2: The first header byte gives address bits [12:5]. The second header byte gives address bits [4:0] in bits [7:3] and an op code in bits [2:0]. Op 100b is a write, with address bits [15:13] taken as 0. The first data byte (byte 2 of the frame) is written to that address.
- R3: During a write, every complete data byte produces one reg_wr pulse, at an address one above the previous write, until chip select is released.
- R4: Op 110b means an extension byte follows. In an extension byte, bits [7:5] replace address bits [15:13] and bits [4:2] are the new op code. Bits [1:0] are ignored.
- R5: Extension bytes may be chained without limit. The address bits and the op code of the last one are used, so a write with two extension bytes has its data start at byte 4.
- R6: Op 010b is a read. The next byte is a wait byte: its MOSI value is ignored and spi_miso stays 0 during it. Each byte after the wait byte returns the register at the header address, then at the header address plus 1, and so on, MSB first. Each bit is valid before the rising SCLK edge that samples it. A read frame never pulses reg_wr.
- R7: Any op code other than 010b, 100b or 110b, whether in the second header byte or in an extension byte, makes the block ignore the rest of the frame: no reg_wr and no reg_rd.
- R8: Releasing chip select aborts the frame at any point. A partly shifted byte is discarded without a write, and the next frame is decoded from its first byte.
- R9: A read may also be reached through extension bytes, for example header, extension with op 010b, wait byte, then data, which keeps a 4-byte-granular master aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 while deselected |
| reg_addr | output | 16 | Byte address for the register port |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, sampled the cycle after reg_rd |

## Verification
The bench targets chains of extension bytes whose high address bits differ. A design that kept the first extension's bits, or acted on the first op code, would write to the wrong bank. It sets the reserved bits of an extension byte and sends an unknown op code only after an extension. A design that checked the reserved bits or dropped unknown ops only in the second header byte would write stray data. Read frames check that the wait byte returns zeros and that data appears one byte ahead at successive addresses; a design that skipped the prefetch would return the previous byte or stale data. Aborted frames, cut mid-header and mid-data, must leave no write and must not shift the decoding of the next frame.

// File: rtl/spi_xaddr_pkg.sv
package spi_xaddr_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;
    localparam int OP_W   = 3;
    localparam int HI_W   = 3;   // address bits carried by an extension byte
    localparam int LO_W   = 5;   // address bits carried by the second header byte
    localparam int MID_W  = ADDR_W - HI_W - LO_W;

    localparam logic [OP_W-1:0] OP_READ  = 3'b010;
    localparam logic [OP_W-1:0] OP_WRITE = 3'b100;
    localparam logic [OP_W-1:0] OP_EXTEND = 3'b110;

    typedef enum logic [2:0] {
        PH_HI,     // expecting address bits [12:5]
        PH_LO,     // expecting address bits [4:0] and op
        PH_EXT,    // expecting extension byte
        PH_WAIT,   // read wait byte
        PH_WDATA,  // write data bytes
        PH_RDATA,  // read data bytes
        PH_DROP    // unknown op, ignore until deselect
    } phase_e;

    typedef struct packed {
        logic [LO_W-1:0] a_lo;
        logic [OP_W-1:0] op;
    } lo_byte_t;

    typedef struct packed {
        logic [HI_W-1:0] a_hi;
        logic [OP_W-1:0] op;
        logic [1:0]      rsvd;
    } ext_byte_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } byte_ev_t;

    function automatic phase_e op_to_phase(input logic [OP_W-1:0] op);
        case (op)
            OP_READ:   return PH_WAIT;
            OP_WRITE:  return PH_WDATA;
            OP_EXTEND: return PH_EXT;
            default:   return PH_DROP;
        endcase
    endfunction

endpackage

// File: rtl/spi_xaddr_sync.sv
module spi_xaddr_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/spi_xaddr_shifter.sv
module spi_xaddr_shifter
    import spi_xaddr_pkg::*;
#(
    parameter int W     = BYTE_W,
    localparam int CNT_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_act,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             mosi_bit,
    input  logic             load_en,
    input  logic [W-1:0]     tx_next,
    output byte_ev_t         rx_ev,
    output logic             tx_loaded,
    output logic             miso_bit,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0] rx_sr;
    logic [W-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rx_ev     <= '0;
            tx_loaded <= 1'b0;
        end else begin
            rx_ev.valid <= 1'b0;
            tx_loaded   <= 1'b0;
            if (sclk_rise) begin
                rx_sr   <= {rx_sr[W-2:0], mosi_bit};
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
                if (bit_cnt == LAST) begin
                    rx_ev.valid <= 1'b1;
                    rx_ev.data  <= {rx_sr[W-2:0], mosi_bit};
                end
            end
            if (sclk_fall) begin
                if (bit_cnt == '0) begin
                    // byte boundary: present the next byte's MSB
                    tx_sr     <= load_en ? tx_next : '0;
                    tx_loaded <= load_en;
                end else begin
                    tx_sr <= {tx_sr[W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso_bit = tx_sr[W-1];
endmodule

// File: rtl/spi_xaddr_parser.sv
module spi_xaddr_parser
    import spi_xaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  byte_ev_t          rx_ev,
    input  logic              tx_loaded,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd,
    output logic [BYTE_W-1:0] tx_next,
    output logic              load_en,
    output phase_e            phase
);
    logic [ADDR_W-1:0] ptr;
    logic              rd_pend;
    lo_byte_t          lo_b;
    ext_byte_t         ext_b;
    logic [OP_W-1:0]   hdr_op;
    logic [ADDR_W-1:0] hdr_addr;
    phase_e            hdr_next;

    always_comb begin
        lo_b  = lo_byte_t'(rx_ev.data);
        ext_b = ext_byte_t'(rx_ev.data);
        if (phase == PH_EXT) begin
            hdr_op   = ext_b.op;
            hdr_addr = {ext_b.a_hi, ptr[ADDR_W-HI_W-1:0]};
        end else begin
            hdr_op   = lo_b.op;
            hdr_addr = {ptr[ADDR_W-1:LO_W], lo_b.a_lo};
        end
        hdr_next = op_to_phase(hdr_op);
    end

    assign load_en = (phase == PH_RDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_HI;
            ptr       <= '0;
            rd_pend   <= 1'b0;
            tx_next   <= '0;
            reg_addr  <= '0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr  <= 1'b0;
            reg_rd  <= 1'b0;
            rd_pend <= reg_rd;
            if (rd_pend) tx_next <= reg_rdata;

            if (!cs_act) begin
                phase <= PH_HI;
            end else if (rx_ev.valid) begin
                case (phase)
                    PH_HI: begin
                        ptr   <= {{HI_W{1'b0}}, rx_ev.data[MID_W-1:0], {LO_W{1'b0}}};
                        phase <= PH_LO;
                    end
                    PH_LO, PH_EXT: begin
                        ptr   <= hdr_addr;
                        phase <= hdr_next;
                        if (hdr_next == PH_WAIT) begin
                            reg_rd   <= 1'b1;
                            reg_addr <= hdr_addr;
                        end
                    end
                    PH_WAIT: phase <= PH_RDATA;
                    PH_WDATA: begin
                        reg_wr    <= 1'b1;
                        reg_addr  <= ptr;
                        reg_wdata <= rx_ev.data;
                        ptr       <= ptr + 1'b1;
                    end
                    default: ;
                endcase
            end else if (tx_loaded && phase == PH_RDATA) begin
                // current byte now on MISO: fetch the one after it
                ptr      <= ptr + 1'b1;
                reg_rd   <= 1'b1;
                reg_addr <= ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_xaddr_slave.sv
module spi_xaddr_slave
    import spi_xaddr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [2:0]        pins_s;
    logic              cs_n_s, sclk_s, mosi_s, sclk_d;
    logic              cs_act, sclk_rise, sclk_fall;
    byte_ev_t          rx_ev;
    logic              tx_loaded, miso_bit, load_en;
    logic [BYTE_W-1:0] tx_next;
    logic [CNT_W-1:0]  bit_cnt;
    phase_e            phase;

    spi_xaddr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst),
        .d({spi_cs_n, spi_sclk, spi_mosi}),
        .q(pins_s)
    );

    assign {cs_n_s, sclk_s, mosi_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    assign cs_act    = !cs_n_s;
    assign sclk_rise = sclk_s && !sclk_d;
    assign sclk_fall = !sclk_s && sclk_d;

    spi_xaddr_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .cs_act(cs_act),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_bit(mosi_s),
        .load_en(load_en), .tx_next(tx_next),
        .rx_ev(rx_ev), .tx_loaded(tx_loaded), .miso_bit(miso_bit), .bit_cnt(bit_cnt)
    );

    spi_xaddr_parser u_parse (
        .clk(clk), .rst(rst), .cs_act(cs_act),
        .rx_ev(rx_ev), .tx_loaded(tx_loaded), .reg_rdata(reg_rdata),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .tx_next(tx_next), .load_en(load_en), .phase(phase)
    );

    assign spi_miso = cs_act && miso_bit;
endmodule

// File: rtl/spi_xaddr_slave_chk.sv
module spi_xaddr_slave_chk
    import spi_xaddr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input phase_e            phase,
    input logic [2:0]        bit_cnt,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr
);
    logic              seen_wr;
    logic [ADDR_W-1:0] last_wr;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            seen_wr <= 1'b0;
            last_wr <= '0;
        end else if (reg_wr) begin
            seen_wr <= 1'b1;
            last_wr <= reg_addr;
        end
    end

    // R1: the port never strobes both directions at once
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // R2: a write strobe follows only a byte taken in the write data phase
    a_r2_wr_from_data: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> $past(phase) == PH_WDATA);

    // R3: successive writes in one frame step the address by one
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && seen_wr) |-> reg_addr == last_wr + 16'd1);

    // R6: read frames never write
    a_r6_read_no_wr: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT || phase == PH_RDATA) |-> !reg_wr);

    // R7: dropped frames make no register access
    a_r7_drop_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DROP) |-> (!reg_wr && !reg_rd));

    // R8: deselect returns parsing to the first header byte
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (phase == PH_HI && bit_cnt == 3'd0));
endmodule

bind spi_xaddr_slave spi_xaddr_slave_chk u_chk (
    .clk(clk), .rst(rst), .cs_act(cs_act), .phase(phase), .bit_cnt(bit_cnt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr)
);

// File: tb/spi_xaddr_slave_bench.sv
module spi_xaddr_slave_bench;
    localparam int HP = 6;   // SCLK half period in clk cycles
    localparam int NV = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;    // 250 MHz

    logic        rst, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic [15:0] reg_addr;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_wdata, reg_rdata;

    spi_xaddr_slave u_spi_xaddr_slave (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    assign reg_rdata = mem_f(reg_addr);

    // {len[87:84], data start[83:80], expected address[79:64], bytes[63:0] byte 0 first}
    localparam logic [87:0] VEC [NV] = '{
        {4'd5, 4'd2, 16'h0ABC, 64'h55E4112233000000},   // R2 R3 two-byte write
        {4'd8, 4'd4, 16'hEABC, 64'h55E6F8F044556677},   // R4 R5 data at byte 4
        {4'd6, 4'd4, 16'hAABC, 64'h55E678B099AA0000},   // R5 last extension wins
        {4'd4, 4'd4, 16'h0000, 64'h55E1123400000000},   // R7 bad op in header
        {4'd5, 4'd5, 16'h0000, 64'h55E65CDEAD000000},   // R7 bad op in extension
        {4'd4, 4'd3, 16'h2ABC, 64'h55E6335A00000000}    // R4 reserved bits ignored
    };
    localparam int VTAG [NV] = '{2, 5, 5, 7, 7, 4};

    int checks = 0, errors = 0, wn = 0, rn = 0;
    logic [15:0] wa [64];
    logic [7:0]  wd [64];
    logic [7:0]  rxb [8];
    bit done = 0;

    always @(negedge clk) begin
        if (reg_wr && wn < 64) begin wa[wn] = reg_addr; wd[wn] = reg_wdata; wn++; end
        if (reg_rd) rn++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer_byte(input logic [7:0] tb, input int nbits, output logic [7:0] rb);
        rb = '0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = tb[7-i];
            repeat (HP) @(negedge clk);
            rb[7-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HP) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic frame(input logic [63:0] bytes, input int n, input int last_bits);
        spi_cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int k = 0; k < n; k++)
            xfer_byte(bytes[63-8*k -: 8], (k == n-1) ? last_bits : 8, rxb[k]);
        repeat (HP) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4*HP) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 150000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w0, r0, len, hdr;
        logic [15:0] ea;
        logic [63:0] bs;
        rst = 1'b1; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: idle state
        chk(spi_miso == 1'b0, "R1 miso idle", 32'(spi_miso), 0);
        chk(wn == 0 && rn == 0, "R1 no strobes", wn + rn, 0);

        // vector table: write frames, chained extensions, dropped frames
        for (int v = 0; v < NV; v++) begin
            len = int'(VEC[v][87:84]); hdr = int'(VEC[v][83:80]);
            ea = VEC[v][79:64]; bs = VEC[v][63:0];
            w0 = wn; r0 = rn;
            frame(bs, len, 8);
            chk(wn - w0 == len - hdr, $sformatf("R%0d write count v%0d", VTAG[v], v), wn - w0, len - hdr);
            chk(rn == r0, $sformatf("R%0d no read v%0d", VTAG[v], v), rn - r0, 0);
            for (int j = 0; j < len - hdr && w0 + j < wn; j++) begin
                chk(wa[w0+j] == ea + 16'(j), $sformatf("R3 addr v%0d b%0d", v, j), wa[w0+j], ea + 16'(j));
                chk(wd[w0+j] == bs[63-8*(hdr+j) -: 8], $sformatf("R%0d data v%0d b%0d", VTAG[v], v, j),
                    wd[w0+j], bs[63-8*(hdr+j) -: 8]);
            end
        end

        // R6: two-byte read, wait byte FF, three data bytes
        w0 = wn;
        frame(64'h55E2FF0000000000, 6, 8);
        chk(rxb[2] == 8'h00, "R6 wait byte miso", rxb[2], 0);
        for (int k = 0; k < 3; k++)
            chk(rxb[3+k] == mem_f(16'h0ABC + 16'(k)), $sformatf("R6 read data b%0d", k),
                rxb[3+k], mem_f(16'h0ABC + 16'(k)));
        chk(wn == w0, "R6 read makes no write", wn - w0, 0);

        // R9: read through an extension byte, 4-byte aligned header
        frame(64'h55E6C8A500000000, 6, 8);
        chk(rxb[4] == mem_f(16'hCABC), "R9 ext read b0", rxb[4], mem_f(16'hCABC));
        chk(rxb[5] == mem_f(16'hCABD), "R9 ext read b1", rxb[5], mem_f(16'hCABD));

        // R8: partial data byte is dropped
        w0 = wn;
        frame(64'h55E4AB0000000000, 3, 5);
        chk(wn == w0, "R8 partial byte no write", wn - w0, 0);
        // R8: abort inside the header, then a clean frame
        frame(64'h5500000000000000, 1, 8);
        frame(64'h1D00000000000000, 1, 3);
        w0 = wn;
        frame(64'h55E4770000000000, 3, 8);
        chk(wn - w0 == 1, "R8 restart count", wn - w0, 1);
        if (wn - w0 == 1) begin
            chk(wa[w0] == 16'h0ABC, "R8 restart addr", wa[w0], 16'h0ABC);
            chk(wd[w0] == 8'h77, "R8 restart data", wd[w0], 8'h77);
        end
        chk(spi_miso == 1'b0, "R1 miso after frames", 32'(spi_miso), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule